// File: doc/BRIEF.md
# Asynchronous-Channel Reaction Launcher

This block runs a small synchronous reactive machine on top of message channels that carry no timing information. Each input signal of the machine has its own small queue. A value that is present arrives as one message, and a value that is absent arrives as nothing at all. On every activation tick the block looks at the messages at the queue heads. It evaluates the guard of every reaction, picks one reaction that can fire, removes only the head messages that reaction reads, and places the outputs of the reaction into output slots. Each slot holds its message until the downstream side takes it.

Two reaction sets can be chosen by a parameter. The exclusive set has three boolean inputs and three event outputs. Its guards contradict each other, so at most one reaction is ever fireable. The parallel set forwards input A to output X and input B to output Y, either singly or together. Its guards overlap, and a rotating priority chooses among the fireable reactions.

Top module: `gals_react_wrapper`

## Requirements
- R1: Each input channel i (index 0 = A, 1 = B, 2 = C) accepts a message on a clock edge where in_valid[i] and in_ready[i] are both high. in_ready[i] is low while 4 messages are queued (DEPTH = 4), and it is high otherwise.
- R2: A reaction fires only at a tick and only when every channel it reads has a message at its head.
- R3: With MODE = 0, a message data bit of 1 means true. A=1 with B=1 emits X (out index 0). B=0 with C=0 emits Y (index 1). A=0 with C=1 emits Z (index 2). Output events carry data 1. At most one of these reactions is fireable at any time.
- R4: A firing removes the head message of only the channels the reaction reads. Messages on the other channels stay queued for later reactions.
- R5: A tick at which no reaction is fireable consumes nothing and emits nothing.
- R6: Outputs of a reaction fired at a clock edge become valid right after that edge. Each output stays valid with stable data until a clock edge at which its out_ready is high.
- R7: No reaction fires while any output slot still holds a message. The blocked messages stay queued.
- R8: With MODE = 1, reaction 0 reads A and emits X = A, reaction 1 reads B and emits Y = B, and reaction 2 reads both and emits both. Among fireable reactions, the search starts just after the last granted reaction, and reaction 0 comes first after reset.
- R9: A synchronous reset empties every queue and clears every output slot.
- R10: With MODE = 0, if C=0, B=1, A=1, A=0 and B=0 arrive in that order and a tick follows each group, three ticks yield X, then nothing, then Y.
- R11: The output history depends only on the per-channel message sequences and the ticks, not on the order in which the channels received their messages between ticks.
- R12: Without a tick, no reaction fires and nothing is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Activation request for one reaction |
| in_valid | input | 3 | Message offered on channels A, B, C |
| in_data | input | 3 | Message value per input channel |
| in_ready | output | 3 | Channel queue can accept a message |
| out_valid | output | 3 | Output message held on X, Y, Z |
| out_data | output | 3 | Output message value per channel |
| out_ready | input | 3 | Downstream takes the held output message |

## Verification
The assertions assume that upstream senders respect in_ready, so that no message is pushed into a full queue. The bench only offers messages in counted bursts that stay within the depth. The assertions also assume that out_ready is driven only from the downstream side, with no combinational path back from out_valid. The bench raises out_ready only in separate drain cycles, after each output has been sampled. Stimulus changes at the falling edge, so every message, tick and ready is stable at the rising edge that samples it.

// File: rtl/gals_pkg.sv
package gals_pkg;
  localparam int NSIG = 3;
  localparam int NRX  = 3;

  // channels each reaction reads: bit 0 = A, bit 1 = B, bit 2 = C
  function automatic logic [NSIG-1:0] rx_reads(input int mode, input int r);
    logic [NSIG-1:0] m;
    m = '0;
    if (mode == 0) begin
      case (r)
        0: m = 3'b011;
        1: m = 3'b110;
        default: m = 3'b101;
      endcase
    end else begin
      case (r)
        0: m = 3'b001;
        1: m = 3'b010;
        default: m = 3'b011;
      endcase
    end
    return m;
  endfunction

  // value-dependent part of each guard, over the head data bits
  function automatic logic rx_guard(input int mode, input int r, input logic [NSIG-1:0] hd);
    logic g;
    g = 1'b1;
    if (mode == 0) begin
      case (r)
        0: g = hd[0] & hd[1];
        1: g = ~hd[1] & ~hd[2];
        default: g = ~hd[0] & hd[2];
      endcase
    end
    return g;
  endfunction

  // output channels each reaction emits on
  function automatic logic [NSIG-1:0] rx_emits(input int mode, input int r);
    logic [NSIG-1:0] m;
    if (mode == 0) m = NSIG'(1) << r;
    else begin
      case (r)
        0: m = 3'b001;
        1: m = 3'b010;
        default: m = 3'b011;
      endcase
    end
    return m;
  endfunction

  // value carried by output o
  function automatic logic rx_value(input int mode, input int o, input logic [NSIG-1:0] hd);
    logic v;
    v = 1'b1;
    if (mode != 0) v = (o == 0) ? hd[0] : hd[1];
    return v;
  endfunction
endpackage

// File: rtl/chan_fifo.sv
module chan_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_valid,
  input  logic [W-1:0] push_data,
  output logic         push_ready,
  input  logic         pop,
  output logic         head_valid,
  output logic [W-1:0] head_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          push_fire;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ready = (count != CW'(DEPTH));
  assign push_fire  = push_valid & push_ready;
  assign head_valid = (count != '0);
  assign head_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_fire) wr_ptr <= bump(wr_ptr);
      if (pop)       rd_ptr <= bump(rd_ptr);
      case ({push_fire, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2: a pop is only ever requested for a message that is waiting
  p_pop_has_head_r2: assert property (@(posedge clk) disable iff (rst)
    pop |-> head_valid);
  // R1: occupancy never exceeds the depth
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R1: a full queue refuses the next message
  p_full_refuses_r1: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH)) && !pop |=> (count == CW'(DEPTH)) && $stable(wr_ptr));
endmodule

// File: rtl/react_arbiter.sv
module react_arbiter #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] last;
  logic [PW-1:0] win;
  logic          found;

  always_comb begin
    grant = '0;
    win   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = (int'(last) + 1 + i) % N;
      if (!found && req[idx]) begin
        found = 1'b1;
        win   = PW'(idx);
      end
    end
    if (en && found) grant[win] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)              last <= PW'(N - 1);
    else if (en && found) last <= win;
  end

  // R8: a single reaction is granted per activation
  p_one_grant_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R2: only fireable reactions are granted
  p_grant_fireable_r2: assert property (@(posedge clk) disable iff (rst)
    (grant & ~req) == '0);
  // R12: nothing is granted without an enable
  p_no_en_no_grant_r12: assert property (@(posedge clk) disable iff (rst)
    !en |-> grant == '0);
endmodule

// File: rtl/out_slot.sv
module out_slot #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         valid,
  output logic [W-1:0] data,
  input  logic         ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  // R6: a held message stays with stable value until taken
  p_hold_until_taken_r6: assert property (@(posedge clk) disable iff (rst)
    valid && !ready |=> valid && $stable(data));
  // R7: a slot is never reloaded while it still holds a message
  p_no_reload_r7: assert property (@(posedge clk) disable iff (rst)
    load |-> !valid);
endmodule

// File: rtl/gals_react_wrapper.sv
module gals_react_wrapper
  import gals_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int MODE  = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [NSIG-1:0] in_valid,
  input  logic [NSIG-1:0] in_data,
  output logic [NSIG-1:0] in_ready,
  output logic [NSIG-1:0] out_valid,
  output logic [NSIG-1:0] out_data,
  input  logic [NSIG-1:0] out_ready
);
  logic [NSIG-1:0] avail, head, pop, emit;
  logic [NRX-1:0]  fireable, grant;
  logic            busy, launch_en, fire;

  genvar gi;
  generate
    for (gi = 0; gi < NSIG; gi++) begin : g_chan
      chan_fifo #(.DEPTH(DEPTH), .W(1)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push_valid (in_valid[gi]),
        .push_data  (in_data[gi]),
        .push_ready (in_ready[gi]),
        .pop        (pop[gi]),
        .head_valid (avail[gi]),
        .head_data  (head[gi])
      );
    end

    for (gi = 0; gi < NRX; gi++) begin : g_guard
      localparam logic [NSIG-1:0] RD = rx_reads(MODE, gi);
      assign fireable[gi] = ((RD & avail) == RD) && rx_guard(MODE, gi, head);
    end
  endgenerate

  assign busy      = |out_valid;
  assign launch_en = tick & ~busy;

  react_arbiter #(.N(NRX)) u_arb (
    .clk   (clk),
    .rst   (rst),
    .en    (launch_en),
    .req   (fireable),
    .grant (grant)
  );

  assign fire = |grant;

  always_comb begin
    pop  = '0;
    emit = '0;
    for (int r = 0; r < NRX; r++) begin
      if (grant[r]) begin
        pop  = pop  | rx_reads(MODE, r);
        emit = emit | rx_emits(MODE, r);
      end
    end
  end

  generate
    for (gi = 0; gi < NSIG; gi++) begin : g_out
      out_slot #(.W(1)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .load      (emit[gi]),
        .load_data (rx_value(MODE, gi, head)),
        .valid     (out_valid[gi]),
        .data      (out_data[gi]),
        .ready     (out_ready[gi])
      );
    end

    if (MODE == 0) begin : g_excl_chk
      // R3: the exclusive guards never overlap
      p_guards_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fireable));
    end
  endgenerate

  // R5: a tick with nothing fireable leaves queues and outputs untouched
  p_stutter_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    tick && (fireable == '0) |-> (pop == '0) && (emit == '0));
  // R7: no firing while any output is pending
  p_pending_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !fire);
  // R6: a firing is followed by at least one held output
  p_fire_emits_r6: assert property (@(posedge clk) disable iff (rst)
    fire |=> (out_valid != '0));
  // R4: a pop only touches channels that were present at the head
  p_pop_subset_r4: assert property (@(posedge clk) disable iff (rst)
    (pop & ~avail) == '0);
endmodule

// File: tb/test_gals_react_wrapper.sv
module test_gals_react_wrapper;
  logic       clk = 1'b0;
  logic       rst;
  logic       tick;
  logic [2:0] in_valid, in_data, in_ready, out_valid, out_data, out_ready;
  logic [2:0] p_in_valid, p_in_data, p_in_ready, p_out_valid, p_out_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  gals_react_wrapper #(.DEPTH(4), .MODE(0)) i_gals_react_wrapper (
    .clk(clk), .rst(rst), .tick(tick),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  gals_react_wrapper #(.DEPTH(4), .MODE(1)) i_gals_react_wrapper_par (
    .clk(clk), .rst(rst), .tick(tick),
    .in_valid(p_in_valid), .in_data(p_in_data), .in_ready(p_in_ready),
    .out_valid(p_out_valid), .out_data(p_out_data), .out_ready(out_ready)
  );

  // {a_v,a_d,b_v,b_d,c_v,c_d,exp_z,exp_y,exp_x}
  localparam logic [8:0] VEC [8] = '{
    9'b111110_001,   // R10: C=0,B=1,A=1 -> X
    9'b100000_000,   // R10: A=0 -> stutter
    9'b001000_010,   // R10: B=0 -> Y, A=0 left queued
    9'b000011_100,   // R4: queued A=0 with C=1 -> Z
    9'b111010_010,   // R3: A=1,B=0,C=0 -> Y, A=1 stays
    9'b001100_001,   // R4: B=1 meets queued A=1 -> X
    9'b000000_000,   // R5: empty queues, stutter
    9'b111011_000    // R5: A=1,B=0,C=1 fires nothing
  };

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] v, input logic [2:0] d);
    in_valid = v; in_data = d; cyc(); in_valid = '0;
  endtask

  task automatic ppush(input logic [2:0] v, input logic [2:0] d);
    p_in_valid = v; p_in_data = d; cyc(); p_in_valid = '0;
  endtask

  task automatic pulse();
    tick = 1'b1; cyc(); tick = 1'b0;
  endtask

  task automatic drain();
    out_ready = 3'b111; cyc(); out_ready = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tick = 1'b0; out_ready = '0;
    in_valid = '0; in_data = '0; p_in_valid = '0; p_in_data = '0;
    repeat (3) cyc();
    chk("R9 reset out_valid", 32'(out_valid), 0);
    chk("R9 reset in_ready", 32'(in_ready), 32'h7);
    rst = 1'b0;
    cyc();

    // vector table: R3 R4 R5 R10
    for (int k = 0; k < 8; k++) begin
      logic [8:0] v;
      v = VEC[k];
      push({v[4], v[6], v[8]}, {v[3], v[5], v[7]});
      pulse();
      chk($sformatf("R3/R10 vec%0d out_valid", k), 32'(out_valid), 32'(v[2:0]));
      chk($sformatf("R3 vec%0d out_data", k), 32'(out_data & out_valid), 32'(v[2:0]));
      drain();
      chk($sformatf("R6 vec%0d drained", k), 32'(out_valid), 0);
    end

    // R1: A queue holds 1 from the last vector, add 3 more to fill it
    push(3'b001, 3'b001); push(3'b001, 3'b001); push(3'b001, 3'b001);
    chk("R1 full queue ready", 32'(in_ready), 32'h6);

    // R9: reset empties queues; B alone must not fire X afterwards
    rst = 1'b1; cyc(); rst = 1'b0;
    chk("R9 ready after reset", 32'(in_ready), 32'h7);
    chk("R9 outputs after reset", 32'(out_valid), 0);
    push(3'b010, 3'b010);
    pulse();
    chk("R9 stale A gone", 32'(out_valid), 0);
    // R11: B arrived before A, still X
    push(3'b001, 3'b001);
    pulse();
    chk("R11 order independent X", 32'(out_valid), 32'h1);
    drain();

    // R12 / R7 / R6
    push(3'b011, 3'b011);
    push(3'b011, 3'b011);
    repeat (3) cyc();
    chk("R12 no fire without tick", 32'(out_valid), 0);
    pulse();
    chk("R7 first X", 32'(out_valid), 32'h1);
    pulse();
    chk("R7 blocked while pending", 32'(out_valid), 32'h1);
    cyc();
    chk("R6 held until ready", 32'(out_valid & out_data), 32'h1);
    drain();
    chk("R6 taken", 32'(out_valid), 0);
    pulse();
    chk("R7 blocked pair still queued", 32'(out_valid), 32'h1);
    drain();
    pulse();
    chk("R5 empty stutter", 32'(out_valid), 0);

    // R4: C waits through an X reaction
    push(3'b100, 3'b000);
    push(3'b011, 3'b011);
    pulse();
    chk("R4 X with C pending", 32'(out_valid), 32'h1);
    drain();
    push(3'b010, 3'b000);
    pulse();
    chk("R4 kept C feeds Y", 32'(out_valid), 32'h2);
    drain();

    // R8: rotating priority in parallel mode
    ppush(3'b011, 3'b001);
    pulse();
    chk("R8 first grant r0 valid", 32'(p_out_valid), 32'h1);
    chk("R8 first grant r0 data", 32'(p_out_data[0]), 32'h1);
    drain();
    ppush(3'b001, 3'b000);
    pulse();
    chk("R8 second grant r1 valid", 32'(p_out_valid), 32'h2);
    chk("R8 second grant r1 data", 32'(p_out_data[1]), 32'h0);
    drain();
    ppush(3'b010, 3'b010);
    pulse();
    chk("R8 third grant r2 valid", 32'(p_out_valid), 32'h3);
    chk("R8 third grant r2 data", 32'(p_out_data[1:0]), 32'h2);
    drain();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule